// File: doc/BRIEF.md
# Dynamic per-bank refresh scheduler

This block sits in a memory controller and issues refresh commands to one DRAM rank, one bank at a time. It does not follow a fixed bank rotation. It chooses the bank at run time from the read and write queue occupancy that the command scheduler reports for each bank. Each bank keeps a signed refresh credit. A periodic interval tick lowers the credit of every bank. Each refresh issued to a bank raises that bank's credit. Because the credit is bounded, refreshes can be deferred or pulled in, while the long-run refresh count stays tied to the interval schedule.

Banks that owe refreshes and have empty queues are served first. A bank with pending reads is deferred until its credit reaches the lower bound, and then it is refreshed regardless of its reads. While the command scheduler drains a write batch, refreshes are pulled in early for banks without pending reads, so that they overlap non-critical writes. The block never refreshes two banks in the same cycle and keeps a minimum spacing between refreshes. It flags each refreshed bank busy for the refresh latency, so that the access scheduler can keep using the other banks.

Top module: `refsched_top`

## Requirements
- R1: Under synchronous active-low reset, all credits are 0, `ref_req` is 0 and `bank_busy` is all zeros.
- R2: At most one refresh is issued per cycle, and successive `ref_req` pulses are at least GAP cycles apart (default 4).
- R3: A `refi_tick` lowers every bank's credit by one, and a refresh raises the chosen bank's credit by one. Both in the same cycle leave the credit unchanged. Credit stays within -CREDIT_MAX..+CREDIT_MAX (default 8), and a tick at the lower bound leaves it there.
- R4: Among banks with negative credit and no pending reads, a bank with both queue counts zero is preferred over a bank that only has pending writes.
- R5: A bank with a nonzero read count is not refreshed unless its credit is at the lower bound.
- R6: A bank at credit -CREDIT_MAX is forced: it outranks every other candidate, even when it has pending reads.
- R7: With `drain_mode` high, a bank with credit 0..CREDIT_MAX-1 and no pending reads may receive an early refresh. With `drain_mode` low, a bank with credit at or above zero is never refreshed.
- R8: A bank at credit +CREDIT_MAX is never refreshed.
- R9: Within one priority class (forced, owed idle, owed with writes only, early), the bank with the lowest credit wins, and ties go to the lowest bank index.
- R10: `bank_busy[b]` is high for exactly TRFC cycles (default 6), starting in the cycle `ref_req` names bank b. A busy bank is never selected.
- R11: The choice is made from the inputs in the cycle before a clock edge, and `ref_req` is a one-cycle registered pulse with `ref_bank` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refi_tick | input | 1 | One-cycle pulse per nominal refresh interval |
| drain_mode | input | 1 | High while the command scheduler drains writes |
| rd_pending | input | NUM_BANKS*CNT_W | Per-bank pending read count, bank b at bits [b*CNT_W +: CNT_W] |
| wr_pending | input | NUM_BANKS*CNT_W | Per-bank pending write count, same packing |
| ref_req | output | 1 | Refresh command pulse |
| ref_bank | output | $clog2(NUM_BANKS) | Bank index for the refresh |
| bank_busy | output | NUM_BANKS | Per-bank refresh-in-progress flag |

## Verification
The interval tick and a refresh grant can land on the same bank in the same clock, so its credit must net to zero. The same holds at the lower bound, where a tick must saturate while a forced refresh is pending or being granted. The bench provokes both cases with random tick pulses over long runs in which reads block some banks until they are forced. A behavioural model tracks every bank's credit and busy time and is compared with `ref_req`, `ref_bank` and `bank_busy` on every clock. Directed phases then count per-bank refreshes to judge deferral, forcing and the early-refresh ceiling.

// File: rtl/refsched_pkg.sv
// Shared types for the refresh scheduler.
package refsched_pkg;
    // Priority class of a bank as a refresh candidate; larger wins.
    typedef enum logic [2:0] {
        LVL_NONE      = 3'd0,
        LVL_EARLY     = 3'd1,
        LVL_OWED_WR   = 3'd2,
        LVL_OWED_IDLE = 3'd3,
        LVL_FORCED    = 3'd4
    } lvl_e;
    localparam int LVL_W = 3;
endpackage

// File: rtl/refsched_bank_state.sv
// Per-bank state: signed refresh credit, busy timer and candidate class.
// Assumes grant is only raised for a bank whose class is not LVL_NONE.
module refsched_bank_state
    import refsched_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int CREDIT_MAX = 8,
    parameter int TRFC       = 6,
    localparam int CR_W      = $clog2(CREDIT_MAX + 1) + 1,
    localparam int BUSY_W    = $clog2(TRFC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   grant,
    input  logic                   drain,
    input  logic [CNT_W-1:0]       rd_cnt,
    input  logic [CNT_W-1:0]       wr_cnt,
    output logic signed [CR_W-1:0] credit,
    output logic                   busy,
    output lvl_e                   level
);
    localparam logic signed [CR_W-1:0] CR_HI = CR_W'(CREDIT_MAX);
    localparam logic signed [CR_W-1:0] CR_LO = -CR_HI;

    logic signed [CR_W-1:0] credit_q;
    logic [BUSY_W-1:0]      busy_q;
    logic                   no_rd;
    logic                   no_wr;

    // Credit tracking: tick lowers, grant raises, saturate at the lower bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else begin
            case ({grant, tick})
                2'b10:   credit_q <= credit_q + CR_W'(1);
                2'b01:   credit_q <= (credit_q == CR_LO) ? CR_LO : credit_q - CR_W'(1);
                default: credit_q <= credit_q;
            endcase
        end
    end

    // Busy timer: loaded on grant, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (grant) begin
            busy_q <= BUSY_W'(TRFC);
        end else if (busy_q != '0) begin
            busy_q <= busy_q - BUSY_W'(1);
        end
    end

    assign no_rd  = (rd_cnt == '0);
    assign no_wr  = (wr_cnt == '0);
    assign credit = credit_q;
    assign busy   = (busy_q != '0);

    // Candidate classification from credit, queues and drain state.
    always_comb begin
        if (busy) begin
            level = LVL_NONE;
        end else if (credit_q <= CR_LO) begin
            level = LVL_FORCED;
        end else if (credit_q < 0 && no_rd && no_wr) begin
            level = LVL_OWED_IDLE;
        end else if (credit_q < 0 && no_rd) begin
            level = LVL_OWED_WR;
        end else if (drain && no_rd && credit_q >= 0 && credit_q < CR_HI) begin
            level = LVL_EARLY;
        end else begin
            level = LVL_NONE;
        end
    end
endmodule

// File: rtl/refsched_arbiter.sv
// Picks one bank: highest class, then lowest credit, then lowest index.
// Assumes NUM_BANKS >= 2. Purely combinational.
module refsched_arbiter
    import refsched_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CR_W      = 5,
    localparam int IDX_W    = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS*LVL_W-1:0] lvl_flat,
    input  logic [NUM_BANKS*CR_W-1:0]  cred_flat,
    output logic                       found,
    output logic [IDX_W-1:0]           sel
);
    lvl_e                   best_l;
    logic signed [CR_W-1:0] best_c;

    // Linear scan; strict comparisons keep the lowest index on ties.
    always_comb begin
        best_l = LVL_NONE;
        best_c = '0;
        sel    = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (lvl_e'(lvl_flat[i*LVL_W +: LVL_W]) != LVL_NONE &&
                (lvl_e'(lvl_flat[i*LVL_W +: LVL_W]) > best_l ||
                 (lvl_e'(lvl_flat[i*LVL_W +: LVL_W]) == best_l &&
                  $signed(cred_flat[i*CR_W +: CR_W]) < best_c))) begin
                best_l = lvl_e'(lvl_flat[i*LVL_W +: LVL_W]);
                best_c = $signed(cred_flat[i*CR_W +: CR_W]);
                sel    = IDX_W'(i);
            end
        end
        found = (best_l != LVL_NONE);
    end
endmodule

// File: rtl/refsched_top.sv
// Dynamic per-bank refresh scheduler for one rank.
// Assumes refi_tick pulses no faster than the spacing allows all owed banks
// to be served; rd/wr counts and drain_mode come from the command scheduler.
module refsched_top
    import refsched_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int CNT_W      = 4,
    parameter int CREDIT_MAX = 8,
    parameter int TRFC       = 6,
    parameter int GAP        = 4,
    localparam int IDX_W     = $clog2(NUM_BANKS),
    localparam int CR_W      = $clog2(CREDIT_MAX + 1) + 1,
    localparam int GAP_W     = $clog2(GAP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       refi_tick,
    input  logic                       drain_mode,
    input  logic [NUM_BANKS*CNT_W-1:0] rd_pending,
    input  logic [NUM_BANKS*CNT_W-1:0] wr_pending,
    output logic                       ref_req,
    output logic [IDX_W-1:0]           ref_bank,
    output logic [NUM_BANKS-1:0]       bank_busy
);
    logic [NUM_BANKS*LVL_W-1:0] lvl_flat;
    logic [NUM_BANKS*CR_W-1:0]  cred_flat;
    logic [NUM_BANKS-1:0]       grant;
    logic                       found;
    logic [IDX_W-1:0]           sel;
    logic [GAP_W-1:0]           gap_q;
    logic                       issue;

    assign issue = found && (gap_q == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        lvl_e lvl_b;
        logic signed [CR_W-1:0] cr_b;

        assign grant[b] = issue && (sel == IDX_W'(b));

        refsched_bank_state #(
            .CNT_W      (CNT_W),
            .CREDIT_MAX (CREDIT_MAX),
            .TRFC       (TRFC)
        ) u_state (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (refi_tick),
            .grant  (grant[b]),
            .drain  (drain_mode),
            .rd_cnt (rd_pending[b*CNT_W +: CNT_W]),
            .wr_cnt (wr_pending[b*CNT_W +: CNT_W]),
            .credit (cr_b),
            .busy   (bank_busy[b]),
            .level  (lvl_b)
        );

        assign lvl_flat[b*LVL_W +: LVL_W] = lvl_b;
        assign cred_flat[b*CR_W +: CR_W]  = cr_b;
    end

    refsched_arbiter #(
        .NUM_BANKS (NUM_BANKS),
        .CR_W      (CR_W)
    ) u_arb (
        .lvl_flat  (lvl_flat),
        .cred_flat (cred_flat),
        .found     (found),
        .sel       (sel)
    );

    // Spacing timer: blocks issue for GAP-1 cycles after each refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (issue) begin
            gap_q <= GAP_W'(GAP - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - GAP_W'(1);
        end
    end

    // Output register: one-cycle command pulse with its bank index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_req  <= 1'b0;
            ref_bank <= '0;
        end else begin
            ref_req <= issue;
            if (issue) begin
                ref_bank <= sel;
            end
        end
    end
endmodule

// File: rtl/refsched_chk.sv
// Property checker for refsched_top, attached by bind below.
module refsched_chk #(
    parameter int NUM_BANKS  = 8,
    parameter int CNT_W      = 4,
    parameter int CREDIT_MAX = 8,
    parameter int GAP        = 4,
    parameter int CR_W       = 5,
    localparam int IDX_W     = $clog2(NUM_BANKS),
    localparam int SP_W      = $clog2(GAP + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ref_req,
    input logic [IDX_W-1:0]           ref_bank,
    input logic [NUM_BANKS-1:0]       bank_busy,
    input logic [NUM_BANKS*CNT_W-1:0] rd_pending,
    input logic [NUM_BANKS*CR_W-1:0]  cred_flat
);
    logic [SP_W-1:0] since_q;

    // Cycles since the last observed refresh pulse, saturating at GAP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= SP_W'(GAP);
        end else if (ref_req) begin
            since_q <= SP_W'(1);
        end else if (since_q != SP_W'(GAP)) begin
            since_q <= since_q + SP_W'(1);
        end
    end

    p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> since_q >= SP_W'(GAP));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_credit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $signed(cred_flat[b*CR_W +: CR_W]) <= CREDIT_MAX &&
            $signed(cred_flat[b*CR_W +: CR_W]) >= -CREDIT_MAX);

        p_read_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_req && ref_bank == IDX_W'(b)) |->
            ($past(rd_pending[b*CNT_W +: CNT_W]) == '0 ||
             $signed($past(cred_flat[b*CR_W +: CR_W])) == -CREDIT_MAX));

        p_no_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_req && ref_bank == IDX_W'(b)) |->
            $signed($past(cred_flat[b*CR_W +: CR_W])) < CREDIT_MAX);

        p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bank_busy[b]) |-> (ref_req && ref_bank == IDX_W'(b)));

        p_not_busy_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_req && ref_bank == IDX_W'(b)) |-> !$past(bank_busy[b]));
    end
endmodule

bind refsched_top refsched_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .CNT_W      (CNT_W),
    .CREDIT_MAX (CREDIT_MAX),
    .GAP        (GAP),
    .CR_W       (CR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_req    (ref_req),
    .ref_bank   (ref_bank),
    .bank_busy  (bank_busy),
    .rd_pending (rd_pending),
    .cred_flat  (cred_flat)
);

// File: tb/refsched_top_tb.sv
// Bench: behavioural reference model compared with the outputs every clock.
module refsched_top_tb;
    localparam int N    = 8;
    localparam int CW   = 4;
    localparam int MAXC = 8;
    localparam int TRFC = 6;
    localparam int GAP  = 4;
    localparam int IW   = $clog2(N);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              refi_tick;
    logic              drain_mode;
    logic [N*CW-1:0]   rd_pending;
    logic [N*CW-1:0]   wr_pending;
    logic              ref_req;
    logic [IW-1:0]     ref_bank;
    logic [N-1:0]      bank_busy;

    refsched_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .refi_tick  (refi_tick),
        .drain_mode (drain_mode),
        .rd_pending (rd_pending),
        .wr_pending (wr_pending),
        .ref_req    (ref_req),
        .ref_bank   (ref_bank),
        .bank_busy  (bank_busy)
    );

    int    errors = 0;
    int    checks = 0;
    int    rd_v[N];
    int    wr_v[N];
    int    m_cr[N];
    int    m_busy[N];
    int    m_gap;
    bit    m_req;
    int    m_bank;
    int    ref_cnt[N];
    int    n_ref;
    int    first_bank;
    string tag;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rd_pending[i*CW +: CW] = CW'(rd_v[i]);
            wr_pending[i*CW +: CW] = CW'(wr_v[i]);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int cls(int b);
        if (m_busy[b] > 0) return 0;
        if (m_cr[b] <= -MAXC) return 4;
        if (rd_v[b] == 0 && m_cr[b] < 0) return (wr_v[b] == 0) ? 3 : 2;
        if (drain_mode && rd_v[b] == 0 && m_cr[b] < MAXC) return 1;
        return 0;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < N; b++) begin
            m_cr[b] = 0; m_busy[b] = 0; ref_cnt[b] = 0;
        end
        m_gap = 0; m_req = 0; m_bank = 0; n_ref = 0; first_bank = -1;
    endtask

    // One clock of the reference model, then compare at the falling edge.
    task automatic cyc();
        bit got;
        int pick;
        int exp_busy;
        got = 0; pick = 0;
        for (int lv = 4; lv >= 1; lv--)
            for (int c = -MAXC; c <= MAXC; c++)
                for (int b = 0; b < N; b++)
                    if (!got && cls(b) == lv && m_cr[b] == c) begin
                        got = 1; pick = b;
                    end
        m_req = got && (m_gap == 0);
        if (m_req) m_bank = pick;
        for (int b = 0; b < N; b++) begin
            if (m_req && b == pick) m_cr[b]++;
            if (refi_tick) m_cr[b] = (m_cr[b] - 1 < -MAXC) ? -MAXC : m_cr[b] - 1;
            if (m_req && b == pick) m_busy[b] = TRFC;
            else if (m_busy[b] > 0) m_busy[b]--;
        end
        if (m_req) m_gap = GAP - 1;
        else if (m_gap > 0) m_gap--;
        @(negedge clk);
        check({tag, " R2/R11 ref_req"}, int'(ref_req), int'(m_req));
        if (m_req) check({tag, " R9 ref_bank"}, int'(ref_bank), m_bank);
        exp_busy = 0;
        for (int b = 0; b < N; b++) if (m_busy[b] > 0) exp_busy |= (1 << b);
        check({tag, " R10 bank_busy"}, int'(bank_busy), exp_busy);
        if (ref_req) begin
            n_ref++;
            ref_cnt[ref_bank]++;
            if (first_bank < 0) first_bank = int'(ref_bank);
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic tick_pulse();
        refi_tick = 1'b1;
        cyc();
        refi_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; refi_tick = 1'b0; drain_mode = 1'b0;
        for (int b = 0; b < N; b++) begin rd_v[b] = 0; wr_v[b] = 0; end
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tag = "R1";
        do_reset();
        check("R1 reset ref_req", int'(ref_req), 0);
        check("R1 reset bank_busy", int'(bank_busy), 0);

        tag = "R7 no drain";
        run(50);
        check("R7 no early refresh without drain", n_ref, 0);

        tag = "R9 idle order";
        tick_pulse();
        run(60);
        check("R9 first bank lowest index", first_bank, 0);
        check("R3 one refresh per bank per tick", n_ref, N);

        tag = "R4 idle first";
        do_reset();
        wr_v[0] = 3;
        tick_pulse();
        run(60);
        check("R4 idle bank before write-only", first_bank, 1);
        check("R4 write-only bank still served", ref_cnt[0], 1);

        tag = "R5/R6 reads";
        do_reset();
        rd_v[2] = 5;
        for (int t = 0; t < MAXC - 1; t++) begin tick_pulse(); run(45); end
        check("R5 reads defer refresh", ref_cnt[2], 0);
        tick_pulse();
        run(45);
        check("R6 forced at lower bound", ref_cnt[2], 1);
        rd_v[2] = 0;
        run(60);
        check("R3 owed credit repaid", ref_cnt[2], MAXC);

        tag = "R7/R8 drain";
        do_reset();
        drain_mode = 1'b1;
        for (int b = 0; b < N; b++) wr_v[b] = 2;
        rd_v[5] = 1;
        run(N * MAXC * GAP + 40);
        check("R8 early refreshes stop at ceiling", n_ref, (N - 1) * MAXC);
        check("R5 read bank not pulled in", ref_cnt[5], 0);
        drain_mode = 1'b0;
        rd_v[5] = 0;
        run(30);
        check("R7 nothing after drain ends", n_ref, (N - 1) * MAXC);

        tag = "R3 random";
        do_reset();
        for (int k = 0; k < 6000; k++) begin
            refi_tick = ($urandom_range(0, 24) == 0);
            if ($urandom_range(0, 40) == 0) drain_mode = ~drain_mode;
            for (int b = 0; b < N; b++) begin
                if ($urandom_range(0, 8) == 0) rd_v[b] = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 15) : 0;
                if ($urandom_range(0, 8) == 0) wr_v[b] = ($urandom_range(0, 1) == 0) ? $urandom_range(1, 15) : 0;
            end
            cyc();
        end
        refi_tick = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule